// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the programmed-I/O read and write strobes that a local-bus IDE controller drives toward an attached device. A host programs per-drive timing bytes through a small byte-wide register port; each byte carries an active-phase count and a recovery-phase count, both in local-bus clocks, stored as complemented nibbles whose offsets depend on the controller variant and on a bus-speed strap. When a transfer is requested for a given channel and drive, the block selects the timing register that serves that drive. It asserts the strobe for the active count, keeps it low for the recovery count, and then pulses done.

Two variants are built from one source through the `DUAL` parameter. The dual-channel variant has two timing registers and a control register. Control bit 0 decides whether timers map to drives on a single port or to channels on two ports. The single-channel variant has one timing register, which serves every drive. In that variant, bit 3 of the timing byte always reads as 1, and the active and recovery offsets follow the bus-speed strap.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle or in its done cycle. A request held with `req_valid` while `req_ready` is low simply waits, and its channel, drive and direction must stay stable until it is accepted. Register accesses are plain single-cycle writes with a combinational read port.

Top module: `pio_strobe_timer`

## Requirements
- R1: A timing register reads back exactly the byte last written to it. The timing registers are at address 0 (timer 0) and address 2 (timer 1). In the single-channel variant, bit 3 of timer 0 always reads 1.
- R2: Address 1 is a read-only configuration byte, and writes to it have no effect. Bits 7:4 hold the identification code: 1010 for the dual variant and 1100 for the single variant. Bit 3 is 1 for the dual variant and 0 for the single variant. Bit 2 follows the `bus_slow` input. Bit 1 is the `CTRL_BASE_HI` parameter, and bit 0 is the `IDE_PRIMARY` parameter.
- R3: After reset, every timing register holds its slowest encoding: 0x00 in the dual variant and 0x08 in the single variant. The control register, at address 3, holds 0x5F.
- R4: In the dual variant, the active phase lasts 17 minus the low nibble clocks. The legal range is 2 to 17.
- R5: In the dual variant, the recovery phase lasts 15 minus the high nibble clocks. Any value below 2 is clamped to 2.
- R6: In the single variant with `bus_slow`=1, the active phase lasts 9 minus bits 2:0 clocks and the recovery phase lasts 15 minus the high nibble clocks, which may be 0. With `bus_slow`=0, the active phase lasts 8 minus bits 2:0 clocks and the recovery phase lasts 18 minus the high nibble clocks.
- R7: In the dual variant, when control bit 0 is 1, timer 0 serves drive 0 and timer 1 serves drive 1, whatever the channel. When control bit 0 is 0, timer 0 serves channel 0 and timer 1 serves channel 1, whatever the drive.
- R8: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. The strobe selected by `req_write` (1 selects `strobe_wr`) is high from the next cycle, and `req_ready` stays low while any strobe is high.
- R9: `done` is high for exactly one cycle, the one that follows the last recovery cycle. `req_ready` is high during that cycle, so a request accepted then starts its strobe on the very next cycle.
- R10: A timing-register write made while a transfer is running does not change that transfer. It applies from the next transfer onward.
- R11: In the single variant, every drive and channel uses timer 0. Addresses 2 and 3 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_slow | input | 1 | Bus-speed strap, 1 when the bus runs at 33 MHz or slower |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_chan | input | 1 | Target channel (0 primary, 1 secondary) |
| req_drive | input | 1 | Target drive on the channel |
| req_write | input | 1 | 1 for a write strobe, 0 for a read strobe |
| strobe_rd | output | 1 | Read strobe toward the device, active high |
| strobe_wr | output | 1 | Write strobe toward the device, active high |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Every timing byte is swept through both variants and both strap settings, and the measured strobe width and gap are compared with the arithmetic decode. This sweep catches a wrong offset and a missing clamp. A missing clamp would show up as a recovery gap of 0 or 1 clock, or as a wrapped gap of about 30 clocks, for high nibbles 14 and 15 in the dual variant. A timing register rewritten on the first strobe cycle would expose counts that are not latched at the start, because the running transfer's gap would change. Back-to-back acceptance in the done cycle is checked for a lost cycle or a dropped request. The timer-to-drive map is checked under both settings of control bit 0 using timers with very different widths, so a swapped select shows up as a 2-clock strobe where 17 was expected.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_REC,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] rec;
  } phase_cnt_t;

  localparam logic [1:0] ADDR_TIM0 = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_TIM1 = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  function automatic logic [CNT_W-1:0] clamp_cnt(input int v, input int lo, input int hi);
    int r;
    r = v;
    if (r < lo) r = lo;
    if (r > hi) r = hi;
    return CNT_W'(r);
  endfunction

endpackage

// File: rtl/pio_regs.sv
module pio_regs
  import pio_timer_pkg::*;
#(
  parameter bit DUAL         = 1'b1,
  parameter bit IDE_PRIMARY  = 1'b1,
  parameter bit CTRL_BASE_HI = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_slow,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] tim0,
  output logic [7:0] tim1,
  output logic       map_by_drive
);

  localparam logic [3:0] ID_CODE  = DUAL ? 4'b1010 : 4'b1100;
  localparam logic [7:0] TIM_RST  = DUAL ? 8'h00 : 8'h08;
  localparam logic [7:0] TIM_OR   = DUAL ? 8'h00 : 8'h08;
  localparam logic [7:0] CTRL_RST = 8'h5F;

  logic [7:0] cfg_byte;
  logic [7:0] tim0_q;

  assign cfg_byte = {ID_CODE, DUAL, bus_slow, CTRL_BASE_HI, IDE_PRIMARY};

  always_ff @(posedge clk) begin
    if (!rst_n)                        tim0_q <= TIM_RST;
    else if (wr && addr == ADDR_TIM0)  tim0_q <= wdata | TIM_OR;
  end
  assign tim0 = tim0_q;

  generate
    if (DUAL) begin : g_dual
      logic [7:0] tim1_q;
      logic [7:0] ctrl_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tim1_q <= TIM_RST;
          ctrl_q <= CTRL_RST;
        end else if (wr) begin
          if (addr == ADDR_TIM1) tim1_q <= wdata;
          if (addr == ADDR_CTRL) ctrl_q <= wdata;
        end
      end

      always_comb begin
        unique case (addr)
          ADDR_TIM0: rdata = tim0_q;
          ADDR_CFG:  rdata = cfg_byte;
          ADDR_TIM1: rdata = tim1_q;
          default:   rdata = ctrl_q;
        endcase
      end

      assign tim1         = tim1_q;
      assign map_by_drive = ctrl_q[0];
    end else begin : g_single
      always_comb begin
        unique case (addr)
          ADDR_TIM0: rdata = tim0_q;
          ADDR_CFG:  rdata = cfg_byte;
          default:   rdata = 8'h00;
        endcase
      end

      assign tim1         = 8'h00;
      assign map_by_drive = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pio_count_decode.sv
module pio_count_decode
  import pio_timer_pkg::*;
#(
  parameter bit DUAL = 1'b1
) (
  input  logic [7:0] timing,
  input  logic       bus_slow,
  output phase_cnt_t cnt
);

  int act_ofs, act_min, act_max;
  int rec_ofs, rec_min, rec_max;

  always_comb begin
    if (DUAL) begin
      act_ofs = 17; act_min = 2; act_max = 17;
      rec_ofs = 15; rec_min = 2; rec_max = 15;
    end else if (bus_slow) begin
      act_ofs = 17; act_min = 2; act_max = 9;
      rec_ofs = 15; rec_min = 0; rec_max = 15;
    end else begin
      act_ofs = 16; act_min = 1; act_max = 8;
      rec_ofs = 18; rec_min = 3; rec_max = 18;
    end
    cnt.act = clamp_cnt(act_ofs - int'(timing[3:0]), act_min, act_max);
    cnt.rec = clamp_cnt(rec_ofs - int'(timing[7:4]), rec_min, rec_max);
  end

endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  phase_cnt_t cnt,
  output logic       req_ready,
  output logic       strobe_rd,
  output logic       strobe_wr,
  output logic       done
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] rec_q;
  logic             dir_q;
  logic             accept;

  assign req_ready = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      rec_q   <= '0;
      dir_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            state_q <= ST_ACT;
            left_q  <= cnt.act - 1'b1;
            rec_q   <= cnt.rec;
            dir_q   <= req_write;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ACT: begin
          if (left_q == '0) begin
            if (rec_q == '0) begin
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_REC;
              left_q  <= rec_q - 1'b1;
            end
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        default: begin
          if (left_q == '0) state_q <= ST_DONE;
          else              left_q  <= left_q - 1'b1;
        end
      endcase
    end
  end

  assign strobe_rd = (state_q == ST_ACT) && !dir_q;
  assign strobe_wr = (state_q == ST_ACT) &&  dir_q;
  assign done      = (state_q == ST_DONE);

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_timer_pkg::*;
#(
  parameter bit DUAL         = 1'b1,
  parameter bit IDE_PRIMARY  = 1'b1,
  parameter bit CTRL_BASE_HI = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_slow,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_chan,
  input  logic       req_drive,
  input  logic       req_write,
  output logic       strobe_rd,
  output logic       strobe_wr,
  output logic       done
);

  logic [7:0] tim0, tim1, tim_sel;
  logic       map_by_drive;
  logic       use_tim1;
  phase_cnt_t cnt;

  pio_regs #(
    .DUAL(DUAL), .IDE_PRIMARY(IDE_PRIMARY), .CTRL_BASE_HI(CTRL_BASE_HI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_slow(bus_slow),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .tim0(tim0), .tim1(tim1), .map_by_drive(map_by_drive)
  );

  generate
    if (DUAL) begin : g_map_dual
      assign use_tim1 = map_by_drive ? req_drive : req_chan;
    end else begin : g_map_single
      assign use_tim1 = 1'b0 & (req_drive ^ req_chan);
    end
  endgenerate

  assign tim_sel = use_tim1 ? tim1 : tim0;

  pio_count_decode #(.DUAL(DUAL)) u_dec (
    .timing(tim_sel), .bus_slow(bus_slow), .cnt(cnt)
  );

  pio_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .cnt(cnt),
    .req_ready(req_ready), .strobe_rd(strobe_rd), .strobe_wr(strobe_wr),
    .done(done)
  );

endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk #(
  parameter bit DUAL = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       req_valid,
  input logic       req_ready,
  input logic       strobe_rd,
  input logic       strobe_wr,
  input logic       done
);

  localparam int         ACT_MIN = DUAL ? 2 : 1;
  localparam int         ACT_MAX = DUAL ? 17 : 9;
  localparam logic [3:0] ID_CODE = DUAL ? 4'b1010 : 4'b1100;

  logic       stb;
  logic [7:0] run_len;

  assign stb = strobe_rd | strobe_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)   run_len <= '0;
    else if (stb) run_len <= run_len + 8'd1;
    else          run_len <= '0;
  end

  // R8: strobe follows an accepted request on the next cycle
  assert_start_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid && req_ready)) |-> stb);

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> !req_ready);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R4 and R6: every strobe pulse width lies in the legal active range
  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && run_len != 8'd0) |-> (int'(run_len) >= ACT_MIN && int'(run_len) <= ACT_MAX));

  assert_cfg_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[7:4] == ID_CODE));

endmodule

bind pio_strobe_timer pio_strobe_timer_chk #(.DUAL(DUAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .req_valid(req_valid), .req_ready(req_ready),
  .strobe_rd(strobe_rd), .strobe_wr(strobe_wr), .done(done)
);

// File: tb/tb_pio_strobe_timer.sv
`timescale 1ns/1ps
module tb_pio_strobe_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_slow = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       vd = 1'b0, vs = 1'b0;
  logic       req_chan = 1'b0, req_drive = 1'b0, req_write = 1'b0;
  logic [7:0] rd_d, rd_s;
  logic       rdy_d, rdy_s, srd_d, srd_s, swr_d, swr_s, dn_d, dn_s;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pio_strobe_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_slow(bus_slow),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_d),
    .req_valid(vd), .req_ready(rdy_d), .req_chan(req_chan), .req_drive(req_drive),
    .req_write(req_write), .strobe_rd(srd_d), .strobe_wr(swr_d), .done(dn_d)
  );

  pio_strobe_timer #(.DUAL(1'b0)) dut_single (
    .clk(clk), .rst_n(rst_n), .bus_slow(bus_slow),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_s),
    .req_valid(vs), .req_ready(rdy_s), .req_chan(req_chan), .req_drive(req_drive),
    .req_write(req_write), .strobe_rd(srd_s), .strobe_wr(swr_s), .done(dn_s)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input bit sgl, input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    if (sgl) check(rd_s == exp, req, rd_s, exp);
    else     check(rd_d == exp, req, rd_d, exp);
  endtask

  function automatic logic o_stb(input bit sgl);
    return sgl ? (srd_s | swr_s) : (srd_d | swr_d);
  endfunction

  function automatic logic o_done(input bit sgl);
    return sgl ? dn_s : dn_d;
  endfunction

  function automatic logic o_rdy(input bit sgl);
    return sgl ? rdy_s : rdy_d;
  endfunction

  function automatic logic o_dir_ok(input bit sgl, input logic wr);
    if (sgl) return wr ? (swr_s && !srd_s) : (srd_s && !swr_s);
    return wr ? (swr_d && !srd_d) : (srd_d && !swr_d);
  endfunction

  // one transfer; optional timer-0 rewrite on the first strobe cycle
  task automatic xfer(input bit sgl, input logic ch, input logic drv, input logic wr,
                      input int exp_act, input int exp_rec, input bit mid,
                      input logic [7:0] mid_val, input string req);
    int act_n = 0;
    int rec_n = 0;
    @(negedge clk);
    req_chan = ch; req_drive = drv; req_write = wr;
    if (sgl) vs = 1'b1; else vd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vs = 1'b0; vd = 1'b0;
    check(o_dir_ok(sgl, wr), "R8 strobe direction", int'(o_stb(sgl)), 1);
    check(!o_rdy(sgl), "R8 ready low while strobing", int'(o_rdy(sgl)), 0);
    while (o_stb(sgl) && act_n < 40) begin
      if (act_n == 0 && mid) begin
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = mid_val;
      end else begin
        reg_wr = 1'b0;
      end
      act_n++;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    while (!o_done(sgl) && rec_n < 40) begin
      rec_n++;
      @(negedge clk);
    end
    check(act_n == exp_act, {req, " active"}, act_n, exp_act);
    check(rec_n == exp_rec, {req, " recovery"}, rec_n, exp_rec);
    check(o_rdy(sgl), "R9 ready in done cycle", int'(o_rdy(sgl)), 1);
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset values
    rreg(0, 2'd0, 8'h00, "R3 dual timer0 reset");
    rreg(0, 2'd2, 8'h00, "R3 dual timer1 reset");
    rreg(0, 2'd3, 8'h5F, "R3 control reset");
    rreg(1, 2'd0, 8'h08, "R3 single timer0 reset");

    // R2 config byte, write ignored
    rreg(0, 2'd1, 8'hAD, "R2 dual config slow");
    rreg(1, 2'd1, 8'hC5, "R2 single config slow");
    wreg(2'd1, 8'h00);
    rreg(0, 2'd1, 8'hAD, "R2 dual config after write");
    bus_slow = 1'b0;
    rreg(1, 2'd1, 8'hC1, "R2 single config fast");
    bus_slow = 1'b1;

    // R1 readback, R11 single holes
    wreg(2'd0, 8'hA5);
    rreg(0, 2'd0, 8'hA5, "R1 dual timer0 readback");
    rreg(1, 2'd0, 8'hAD, "R1 single timer0 bit3 forced");
    wreg(2'd2, 8'h5A);
    rreg(0, 2'd2, 8'h5A, "R1 dual timer1 readback");
    rreg(1, 2'd2, 8'h00, "R11 single timer1 absent");
    wreg(2'd3, 8'h5F);
    rreg(1, 2'd3, 8'h00, "R11 single control absent");

    // R4 R5 exhaustive dual decode through timer0 (control bit0=1, drive 0)
    for (int v = 0; v < 256; v++) begin
      wreg(2'd0, 8'(v));
      xfer(0, 1'b1, 1'b0, v[0], 17 - (v % 16), clampi(15 - v / 16, 2, 15), 0, 8'h00,
           "R4 R5 dual decode");
    end

    // R6 R11 exhaustive single decode, both straps, odd drive/channel
    for (int s = 0; s < 2; s++) begin
      bus_slow = s[0];
      for (int v = 0; v < 256; v++) begin
        wreg(2'd0, 8'(v));
        if (s == 1)
          xfer(1, 1'b1, 1'b1, v[1], 9 - (v % 8), 15 - v / 16, 0, 8'h00, "R6 R11 single slow");
        else
          xfer(1, 1'b1, 1'b1, v[1], 8 - (v % 8), 18 - v / 16, 0, 8'h00, "R6 R11 single fast");
      end
    end
    bus_slow = 1'b1;

    // R7 timer mapping
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'h0F);
    wreg(2'd3, 8'h5F);
    xfer(0, 1'b0, 1'b1, 1'b0, 2, 15, 0, 8'h00, "R7 by-drive drive1");
    xfer(0, 1'b1, 1'b0, 1'b0, 17, 15, 0, 8'h00, "R7 by-drive drive0");
    wreg(2'd3, 8'h5E);
    xfer(0, 1'b1, 1'b0, 1'b1, 2, 15, 0, 8'h00, "R7 by-channel chan1");
    xfer(0, 1'b0, 1'b1, 1'b1, 17, 15, 0, 8'h00, "R7 by-channel chan0");
    wreg(2'd3, 8'h5F);

    // R10 mid-transfer write: old counts now, new counts next
    wreg(2'd0, 8'h3C);
    xfer(0, 1'b0, 1'b0, 1'b0, 5, 12, 1, 8'hA7, "R10 running transfer");
    xfer(0, 1'b0, 1'b0, 1'b0, 10, 5, 0, 8'h00, "R10 next transfer");

    // R9 back-to-back acceptance in the done cycle
    wreg(2'd0, 8'hEE);
    @(negedge clk);
    req_chan = 1'b0; req_drive = 1'b0; req_write = 1'b1; vd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vd = 1'b0;
    for (int k = 0; k < 40 && !dn_d; k++) @(negedge clk);
    check(dn_d, "R9 first done seen", int'(dn_d), 1);
    vd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vd = 1'b0;
    check(swr_d && !dn_d, "R9 back-to-back strobe next cycle", int'(swr_d), 1);
    for (int k = 0; k < 40 && !dn_d; k++) @(negedge clk);
    @(negedge clk);
    check(!dn_d && rdy_d, "R9 done lasts one cycle", int'(dn_d), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule